// File: doc/BRIEF.md
# Page-Table-Aware Victim Selector for a Second-Level Cache

This block picks the way to evict on every miss of one set-associative second-level cache. It tracks the full recency order of each set and a one-bit tag per way that marks a block filled with a data page-table entry. When the least-recent way holds such an entry, the selector may pass it over. It then takes the least-recent way that does not hold one, searching only the oldest positions of the recency order.

That preference is gated by measured translation pressure. A separate monitor counts retired instructions in fixed windows and counts last-level TLB misses inside each window. At each window boundary it switches the preference on if enough misses occurred and off otherwise. While the preference is off the selector is a plain LRU.

Each cycle the cache presents at most one access: set index, hit/miss, hit way and the page-table flag of the block. On a miss, `victim_way` is valid in the same cycle and the block fills that way on the next clock edge.

Top module: `pte_victim_sel`

## Requirements
- R1: After reset `pref_on` is 0. Every set's recency order places way w at position w, with position 0 as MRU and position WAYS-1 as LRU. Every page-table tag is 0, so the first miss to any set gets way WAYS-1.
- R2: A hit moves the hit way to position 0. Every way that was more recent than it moves one position older. All other positions are unchanged.
- R3: A miss fills `victim_way`. That way moves to position 0 with the same aging rule as R2, and its page-table tag takes the value of `acc_is_pte`.
- R4: While `pref_on` is 0, `victim_way` is the way at position WAYS-1, whatever the tags.
- R5: While `pref_on` is 1, `victim_way` is the way at the oldest position among positions WAYS-ALT_SPAN to WAYS-1 whose tag is 0 (ALT_SPAN defaults to 8).
- R6: While `pref_on` is 1 and all ways in positions WAYS-ALT_SPAN to WAYS-1 carry tag 1, `victim_way` is the way at position WAYS-1.
- R7: A window ends on the WINDOW-th cycle with `inst_retire` high, counted since reset or since the previous window end. If that window counted at least MISS_THRESH cycles with `tlb_miss` high (including the last cycle), `pref_on` is 1 from the following cycle. The counters then restart from zero.
- R8: At a window end with fewer than MISS_THRESH misses, `pref_on` becomes 0 from the following cycle.
- R9: `pref_on` changes only in the cycle after a window end.
- R10: A hit does not change the page-table tag of the hit way, whatever `acc_is_pte` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | $clog2(SETS) | Set index of the access |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_hit_way | input | $clog2(WAYS) | Way that hit (used when acc_hit=1) |
| acc_is_pte | input | 1 | Block is a data page-table entry (stored on fill only) |
| inst_retire | input | 1 | One instruction retired this cycle |
| tlb_miss | input | 1 | One last-level TLB miss this cycle |
| victim_way | output | $clog2(WAYS) | Way to evict for the presented set (combinational) |
| pref_on | output | 1 | Page-table-entry preference currently active |

## Verification
On every cycle, assertions check four properties. Each set's recency positions form a permutation. A victim other than the plain LRU way is untagged, lies in the searched range and appears only while the preference is on. The window counter stays in bounds, and `pref_on` moves only after a window boundary. The exact choice among candidates depends on the history of hits and fills, and so does the exact window alignment and the fact that hits leave tags alone. Only the bench scenarios show these. They compare every miss against an arithmetic recency model across sweeps, windows with and without misses, and a long pseudo-random mix.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

   // Source of the chosen victim.
   typedef enum logic {
      PICK_LRU = 1'b0,
      PICK_ALT = 1'b1
   } pick_src_e;

endpackage

// File: rtl/pvs_set_state.sv
module pvs_set_state #(
   parameter int WAYS  = 16,
   parameter int SETS  = 16,
   parameter int WAY_W = $clog2(WAYS),
   parameter int SET_W = $clog2(SETS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [SET_W-1:0]            set_idx,
   input  logic                        upd_en,
   input  logic [WAY_W-1:0]            upd_way,
   input  logic                        upd_fill,
   input  logic                        upd_pte,
   output logic [WAYS-1:0][WAY_W-1:0]  rd_pos,
   output logic [WAYS-1:0]             rd_pte
);

   logic [WAYS-1:0][WAY_W-1:0] pos_q [SETS];
   logic [WAYS-1:0]            pte_q [SETS];
   logic [WAY_W-1:0]           touched_pos;

   assign rd_pos      = pos_q[set_idx];
   assign rd_pte      = pte_q[set_idx];
   assign touched_pos = rd_pos[upd_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            pte_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) pos_q[s][w] <= WAY_W'(w);
         end
      end else if (upd_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == upd_way)
               pos_q[set_idx][w] <= '0;
            else if (pos_q[set_idx][w] < touched_pos)
               pos_q[set_idx][w] <= pos_q[set_idx][w] + 1'b1;
         end
         if (upd_fill) pte_q[set_idx][upd_way] <= upd_pte;
      end
   end

   // Every position value appears exactly once in the addressed set.
   logic [WAYS-1:0] pos_seen;
   always_comb begin
      pos_seen = '0;
      for (int w = 0; w < WAYS; w++) pos_seen[rd_pos[w]] = 1'b1;
   end

   assert_stack_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      &pos_seen);

endmodule

// File: rtl/pvs_victim_pick.sv
module pvs_victim_pick
   import pvs_pkg::*;
#(
   parameter int WAYS     = 16,
   parameter int ALT_SPAN = 8,
   parameter int WAY_W    = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enable,
   input  logic [WAYS-1:0][WAY_W-1:0]  pos,
   input  logic [WAYS-1:0]             pte,
   output logic [WAY_W-1:0]            vic_way
);

   localparam logic [WAY_W-1:0] LRU_POS = WAY_W'(WAYS - 1);
   localparam logic [WAY_W-1:0] MIN_POS = WAY_W'(WAYS - ALT_SPAN);

   logic [WAY_W-1:0] lru_way;
   logic [WAY_W-1:0] alt_way;
   logic             alt_found;
   pick_src_e        src;

   always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (pos[w] == LRU_POS) lru_way = WAY_W'(w);
   end

   generate
      if (ALT_SPAN == 1) begin : g_plain
         // A one-deep range can only ever return the LRU way.
         assign alt_way   = lru_way;
         assign alt_found = 1'b0;
      end else begin : g_search
         logic [WAY_W-1:0] best_pos;
         always_comb begin
            alt_way   = '0;
            alt_found = 1'b0;
            best_pos  = '0;
            for (int w = 0; w < WAYS; w++) begin
               if (pos[w] >= MIN_POS && !pte[w] &&
                   (!alt_found || pos[w] > best_pos)) begin
                  alt_found = 1'b1;
                  alt_way   = WAY_W'(w);
                  best_pos  = pos[w];
               end
            end
         end
      end
   endgenerate

   assign src     = (enable && alt_found) ? PICK_ALT : PICK_LRU;
   assign vic_way = (src == PICK_ALT) ? alt_way : lru_way;

   assert_alt_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_way != lru_way) |-> enable);
   assert_alt_untagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_way != lru_way) |-> !pte[vic_way]);
   assert_alt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pos[vic_way] >= MIN_POS);
   assert_all_tagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pte[vic_way] |-> (vic_way == lru_way));

endmodule

// File: rtl/pvs_pressure_mon.sv
module pvs_pressure_mon #(
   parameter int WINDOW      = 1000,
   parameter int MISS_THRESH = 1,
   parameter int CNT_W       = $clog2(WINDOW),
   parameter int MISS_W      = $clog2(MISS_THRESH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inst_retire,
   input  logic tlb_miss,
   output logic pref_on
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [MISS_W-1:0] miss_q;
   logic [MISS_W:0]   miss_sum;
   logic              win_end;
   logic              pref_q;

   assign win_end  = inst_retire && (cnt_q == LAST_CNT);
   assign miss_sum = {1'b0, miss_q} + (MISS_W+1)'(tlb_miss);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         miss_q <= '0;
         pref_q <= 1'b0;
      end else if (win_end) begin
         cnt_q  <= '0;
         miss_q <= '0;
         pref_q <= (miss_sum >= (MISS_W+1)'(MISS_THRESH));
      end else begin
         if (inst_retire) cnt_q <= cnt_q + 1'b1;
         if (tlb_miss && miss_q < MISS_W'(MISS_THRESH)) miss_q <= miss_q + 1'b1;
      end
   end

   assign pref_on = pref_q;

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_CNT);
   assert_pref_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(pref_q));

endmodule

// File: rtl/pte_victim_sel.sv
module pte_victim_sel #(
   parameter int WAYS        = 16,
   parameter int SETS        = 16,
   parameter int ALT_SPAN    = 8,
   parameter int WINDOW      = 1000,
   parameter int MISS_THRESH = 1,
   parameter int WAY_W       = $clog2(WAYS),
   parameter int SET_W       = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [SET_W-1:0] acc_set,
   input  logic             acc_hit,
   input  logic [WAY_W-1:0] acc_hit_way,
   input  logic             acc_is_pte,
   input  logic             inst_retire,
   input  logic             tlb_miss,
   output logic [WAY_W-1:0] victim_way,
   output logic             pref_on
);

   generate
      if (ALT_SPAN < 1 || ALT_SPAN > WAYS) begin : g_bad_span
         $error("ALT_SPAN must lie in 1..WAYS");
      end
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("WAYS must be a power of two, at least 2");
      end
      if (WINDOW < 2 || MISS_THRESH < 1) begin : g_bad_window
         $error("WINDOW must be >= 2 and MISS_THRESH >= 1");
      end
   endgenerate

   logic [WAYS-1:0][WAY_W-1:0] set_pos;
   logic [WAYS-1:0]            set_pte;
   logic [WAY_W-1:0]           upd_way;

   assign upd_way = acc_hit ? acc_hit_way : victim_way;

   pvs_set_state #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_idx  (acc_set),
      .upd_en   (acc_valid),
      .upd_way  (upd_way),
      .upd_fill (!acc_hit),
      .upd_pte  (acc_is_pte),
      .rd_pos   (set_pos),
      .rd_pte   (set_pte)
   );

   pvs_victim_pick #(.WAYS(WAYS), .ALT_SPAN(ALT_SPAN), .WAY_W(WAY_W)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (pref_on),
      .pos     (set_pos),
      .pte     (set_pte),
      .vic_way (victim_way)
   );

   pvs_pressure_mon #(.WINDOW(WINDOW), .MISS_THRESH(MISS_THRESH)) u_mon (
      .clk         (clk),
      .rst_n       (rst_n),
      .inst_retire (inst_retire),
      .tlb_miss    (tlb_miss),
      .pref_on     (pref_on)
   );

endmodule

// File: tb/tb_pte_victim_sel.sv
`timescale 1ns/1ps
module tb_pte_victim_sel;

   localparam int WAYS   = 16;
   localparam int SETS   = 4;
   localparam int SPAN   = 8;
   localparam int WINDOW = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [1:0] acc_set = '0;
   logic       acc_hit = 1'b0;
   logic [3:0] acc_hit_way = '0;
   logic       acc_is_pte = 1'b0;
   logic       inst_retire = 1'b0;
   logic       tlb_miss = 1'b0;
   logic [3:0] victim_way;
   logic       pref_on;

   always #2 clk = ~clk;

   pte_victim_sel #(.WAYS(WAYS), .SETS(SETS), .ALT_SPAN(SPAN), .WINDOW(WINDOW),
                    .MISS_THRESH(1)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
      .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .acc_is_pte(acc_is_pte),
      .inst_retire(inst_retire), .tlb_miss(tlb_miss),
      .victim_way(victim_way), .pref_on(pref_on));

   int total = 0;
   int bad   = 0;
   int mpos [SETS][WAYS];
   bit mtag [SETS][WAYS];
   bit mpref = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_victim(input int s);
      int lru = 0;
      for (int w = 0; w < WAYS; w++) if (mpos[s][w] == WAYS-1) lru = w;
      if (!mpref) return lru;
      for (int q = WAYS-1; q >= WAYS-SPAN; q--)
         for (int w = 0; w < WAYS; w++)
            if (mpos[s][w] == q && !mtag[s][w]) return w;
      return lru;
   endfunction

   function automatic void touch(input int s, input int way);
      int old = mpos[s][way];
      for (int w = 0; w < WAYS; w++)
         if (w == way) mpos[s][w] = 0;
         else if (mpos[s][w] < old) mpos[s][w]++;
   endfunction

   function automatic int rnd();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return int'(lfsr & 32'h7FFF_FFFF);
   endfunction

   task automatic miss(input int s, input bit tag, input string req);
      int e;
      @(negedge clk);
      acc_valid = 1; acc_set = 2'(s); acc_hit = 0; acc_is_pte = tag;
      #1;
      e = exp_victim(s);
      chk(int'(victim_way) == e, req, int'(victim_way), e);
      @(posedge clk);
      touch(s, e);
      mtag[s][e] = tag;
      #0 acc_valid = 0;
   endtask

   task automatic hit(input int s, input int way, input bit tag);
      @(negedge clk);
      acc_valid = 1; acc_set = 2'(s); acc_hit = 1; acc_hit_way = 4'(way);
      acc_is_pte = tag;
      @(posedge clk);
      touch(s, way);
      #0 acc_valid = 0;
   endtask

   task automatic run_window(input bit with_miss, input string req);
      for (int i = 0; i < WINDOW; i++) begin
         @(negedge clk);
         acc_valid = 0; inst_retire = 1; tlb_miss = with_miss && (i == 5);
         #1;
         if (i == WINDOW-1) chk(pref_on == mpref, "R9", int'(pref_on), int'(mpref));
      end
      @(negedge clk);
      inst_retire = 0; tlb_miss = 0;
      mpref = with_miss;
      chk(pref_on == mpref, req, int'(pref_on), int'(mpref));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin mpos[s][w] = w; mtag[s][w] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1: reset state
      #1 chk(pref_on == 0, "R1", int'(pref_on), 0);
      for (int s = 0; s < SETS; s++) begin
         @(negedge clk); acc_set = 2'(s); #1;
         chk(int'(victim_way) == WAYS-1, "R1", int'(victim_way), WAYS-1);
      end

      // R3 R4: fill every set with mixed tags, preference off
      for (int s = 0; s < SETS; s++)
         for (int i = 0; i < WAYS; i++) miss(s, bit'((i + s) % 3 == 0), "R3 R4");
      // R4: all tagged set still yields plain LRU while off
      for (int i = 0; i < WAYS; i++) miss(1, 1'b1, "R4");
      miss(1, 1'b1, "R4");

      // R7 R9: window with a miss turns preference on
      run_window(1'b1, "R7");

      // R6: set 1 fully tagged -> plain LRU
      miss(1, 1'b1, "R6");
      miss(1, 1'b1, "R6");
      // R5: set 2 with oldest three tagged, rest not
      for (int i = 0; i < WAYS; i++) miss(2, bit'(i < 3), "R3");
      miss(2, 1'b0, "R5");
      miss(2, 1'b1, "R5");
      // R2 R10: hit with a tag flag must not retag; then sweep victims
      for (int i = 0; i < WAYS; i++) miss(3, 1'b0, "R3");
      for (int w = 0; w < WAYS; w++) hit(3, w, 1'b1);
      for (int i = 0; i < SPAN; i++) miss(3, 1'b0, "R10");

      // R8: window without misses turns it off
      run_window(1'b0, "R8");
      miss(2, 1'b0, "R4");

      // R2 R5 R10: long pseudo-random mix with windows
      for (int blk = 0; blk < 10; blk++) begin
         for (int n = 0; n < 200; n++) begin
            int s = rnd() % SETS;
            if (rnd() % 3 == 0) miss(s, bit'(rnd() % 2), "R5 R10");
            else hit(s, rnd() % WAYS, bit'(rnd() % 2));
         end
         run_window(bit'(blk % 2 == 0), (blk % 2 == 0) ? "R7" : "R8");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule